// File: doc/BRIEF.md
# LIN Slave Response Transmitter

This block sends the response field of a frame on a single-wire LIN-style bus once the frame header has been decoded and the identifier is one this node answers. A one-cycle `start` pulse with a byte count begins the response. The block fetches each byte from an external response buffer through a combinational read port and sends it as one UART-style character. Each character is a dominant (low) start bit, eight data bits with the least significant bit first, and a recessive (high) stop bit. Every bit lasts `BIT_CLKS` clock cycles, timed by an internal bit counter that starts with the response.

While it drives, the block reads the bus back. In the middle cycle of every bit it compares the received level with the driven level. A mismatch aborts the response at once: the line goes recessive, a one-cycle `bit_error` pulse is raised, and the node is back in its waiting state for the next frame's sync. When the stop bit of the last byte has finished, a one-cycle `done` pulse is raised. After either pulse the block ignores the bus until the next `start`.

Top module: `lin_resp_tx`

## Requirements
- R1: During and after reset, `tx_line` is 1 (recessive), `done` and `bit_error` are 0 and `rd_addr` is 0.
- R2: A `start` sampled while idle with a nonzero `byte_count` reads the byte at `rd_addr` 0 on that edge. The start bit of the first character appears on `tx_line` in the following cycle.
- R3: Each character is sent in this order: bit value 0, then the data bits 0 through 7, then bit value 1. Every bit is held for exactly `BIT_CLKS` cycles.
- R4: Characters follow each other with no gap. Byte k comes from buffer address k. While byte k is on the line, `rd_addr` shows k+1.
- R5: In the cycle where the bit counter equals `BIT_CLKS/2`, a difference between `rx_line` and `tx_line` aborts the response. From the next cycle, `bit_error` is 1 for one cycle, `tx_line` is 1 and `rd_addr` is 0.
- R6: A difference between `rx_line` and `tx_line` in any cycle other than the middle cycle of a bit has no effect on the response.
- R7: In the cycle after the last cycle of the final stop bit, `done` is 1 for one cycle and `tx_line` is 1.
- R8: A `start` sampled while idle with `byte_count` equal to 0 gives a `done` pulse in the next cycle and sends nothing.
- R9: A `start` that arrives while a response is in progress is ignored.
- R10: While idle, `rx_line` has no effect: `tx_line` stays 1 and neither pulse is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to send a response |
| byte_count | input | CNT_W | Number of response bytes, sampled with `start` |
| rd_addr | output | CNT_W | Response buffer read index |
| rd_data | input | 8 | Buffer byte at `rd_addr`, combinational |
| rx_line | input | 1 | Level read back from the bus |
| tx_line | output | 1 | Level driven onto the bus, 1 is recessive |
| done | output | 1 | One-cycle pulse when the whole response is sent |
| bit_error | output | 1 | One-cycle pulse on a readback mismatch |

## Verification
The bench corrupts the readback for a whole bit at several positions. These are the start bit of the first byte, a data bit of a later byte, and the stop bit of the last byte. A design that compares at the wrong point, or keeps driving after the error, is off by one cycle or in level against the reference. A second kind of corruption touches only the cycles around the middle cycle. A design that samples early or late, or on every cycle, would abort a response that should finish. The bench also covers a zero-length request, a second request in the middle of a frame, and a readback held low while idle. These catch a design that shifts stale data, restarts on the second request, or reacts to a line it should not be watching.

// File: rtl/lin_tx_pkg.sv
package lin_tx_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SEND = 1'b1
    } tx_state_e;

    localparam int CHAR_BITS = 10;
    localparam int IDX_W     = $clog2(CHAR_BITS);

    typedef struct packed {
        logic       stop_b;
        logic [7:0] payload;
        logic       start_b;
    } char_frame_t;

    function automatic char_frame_t build_char(input logic [7:0] b);
        char_frame_t f;
        f.stop_b  = 1'b1;
        f.payload = b;
        f.start_b = 1'b0;
        return f;
    endfunction

endpackage

// File: rtl/lin_bit_timer.sv
module lin_bit_timer #(
    parameter int BIT_CLKS = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic at_mid,
    output logic at_last
);
    localparam int TW = (BIT_CLKS > 2) ? $clog2(BIT_CLKS) : 1;
    localparam logic [TW-1:0] MID_V  = TW'(BIT_CLKS / 2);
    localparam logic [TW-1:0] LAST_V = TW'(BIT_CLKS - 1);

    logic [TW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (cnt == LAST_V) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign at_mid  = run && (cnt == MID_V);
    assign at_last = run && (cnt == LAST_V);
endmodule

// File: rtl/lin_char_shift.sv
module lin_char_shift
    import lin_tx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  logic       shift,
    input  logic [7:0] din,
    output logic       bit_out,
    output logic       final_bit
);
    char_frame_t             sreg;
    logic [IDX_W-1:0]        idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            sreg <= build_char(8'hFF) | char_frame_t'(1);
            idx  <= '0;
        end else if (load) begin
            sreg <= build_char(din);
            idx  <= '0;
        end else if (shift) begin
            sreg <= char_frame_t'({1'b1, sreg[CHAR_BITS-1:1]});
            idx  <= idx + 1'b1;
        end
    end

    assign bit_out   = sreg[0];
    assign final_bit = (idx == IDX_W'(CHAR_BITS - 1));
endmodule

// File: rtl/lin_readback_check.sv
module lin_readback_check (
    input  logic sample,
    input  logic driven,
    input  logic heard,
    output logic mismatch
);
    assign mismatch = sample && (driven != heard);
endmodule

// File: rtl/lin_resp_tx.sv
module lin_resp_tx
    import lin_tx_pkg::*;
#(
    parameter int CNT_W    = 4,
    parameter int BIT_CLKS = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [CNT_W-1:0] byte_count,
    output logic [CNT_W-1:0] rd_addr,
    input  logic [7:0]       rd_data,
    input  logic             rx_line,
    output logic             tx_line,
    output logic             done,
    output logic             bit_error
);
    tx_state_e        state;
    logic [CNT_W-1:0] remaining;
    logic [CNT_W-1:0] ptr;
    logic             done_q;
    logic             err_q;

    logic sending;
    logic t_mid, t_last;
    logic sh_bit, sh_final;
    logic mis;
    logic char_end;
    logic ld, sh;

    assign sending  = (state == ST_SEND);
    assign char_end = sending && !mis && t_last && sh_final;

    assign ld = (!sending && start && (byte_count != '0)) ||
                (char_end && (remaining != CNT_W'(1)));
    assign sh = sending && !mis && t_last && !sh_final;

    lin_bit_timer #(.BIT_CLKS(BIT_CLKS)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .run     (sending),
        .at_mid  (t_mid),
        .at_last (t_last)
    );

    lin_char_shift u_shift (
        .clk       (clk),
        .rst       (rst),
        .load      (ld),
        .shift     (sh),
        .din       (rd_data),
        .bit_out   (sh_bit),
        .final_bit (sh_final)
    );

    lin_readback_check u_check (
        .sample   (t_mid),
        .driven   (tx_line),
        .heard    (rx_line),
        .mismatch (mis)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            remaining <= '0;
            ptr       <= '0;
            done_q    <= 1'b0;
            err_q     <= 1'b0;
        end else begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        if (byte_count == '0) begin
                            done_q <= 1'b1;
                        end else begin
                            state     <= ST_SEND;
                            remaining <= byte_count;
                            ptr       <= ptr + 1'b1;
                        end
                    end
                end
                ST_SEND: begin
                    if (mis) begin
                        err_q <= 1'b1;
                        state <= ST_IDLE;
                        ptr   <= '0;
                    end else if (char_end) begin
                        if (remaining == CNT_W'(1)) begin
                            done_q <= 1'b1;
                            state  <= ST_IDLE;
                            ptr    <= '0;
                        end else begin
                            remaining <= remaining - 1'b1;
                            ptr       <= ptr + 1'b1;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign tx_line   = sending ? sh_bit : 1'b1;
    assign rd_addr   = ptr;
    assign done      = done_q;
    assign bit_error = err_q;
endmodule

// File: rtl/lin_resp_tx_chk.sv
module lin_resp_tx_chk #(
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             tx_line,
    input logic             rx_line,
    input logic             done,
    input logic             bit_error,
    input logic [CNT_W-1:0] rd_addr
);
    AST_ERR_FROM_MISMATCH: assert property (@(posedge clk) disable iff (rst)
        bit_error |-> $past(tx_line != rx_line)); // R5

    AST_ERR_RELEASES_LINE: assert property (@(posedge clk) disable iff (rst)
        bit_error |-> (tx_line && rd_addr == '0)); // R5

    AST_DONE_RELEASES_LINE: assert property (@(posedge clk) disable iff (rst)
        done |-> (tx_line && rd_addr == '0)); // R7

    AST_PULSES_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(done && bit_error)); // R10

    AST_ERR_SINGLE: assert property (@(posedge clk) disable iff (rst)
        bit_error |=> !bit_error); // R5
endmodule

bind lin_resp_tx lin_resp_tx_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/tb_lin_resp_tx.sv
module tb_lin_resp_tx;
    localparam int CW  = 4;
    localparam int B   = 8;
    localparam int MID = B / 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [CW-1:0] byte_count = '0;
    logic [CW-1:0] rd_addr;
    logic [7:0]    rd_data;
    logic          rx_line;
    logic          tx_line;
    logic          done;
    logic          bit_error;

    logic [7:0] mem [16];
    logic       flip = 1'b0;
    logic       rx_force = 1'b0;
    logic       s_start;
    logic [CW-1:0] s_cnt;

    int checks = 0;
    int errors = 0;
    string cur_req = "R1";
    bit finished = 0;

    int m_busy = 0, m_t = 0, m_n = 0;
    int inj_mode = 0, inj_bit = -1;

    always #2 clk = ~clk;

    assign rd_data = mem[rd_addr];
    assign rx_line = rx_force ? 1'b0 : (tx_line ^ flip);

    lin_resp_tx #(.CNT_W(CW), .BIT_CLKS(B)) dut (
        .clk(clk), .rst(rst), .start(start), .byte_count(byte_count),
        .rd_addr(rd_addr), .rd_data(rd_data), .rx_line(rx_line),
        .tx_line(tx_line), .done(done), .bit_error(bit_error)
    );

    always @(posedge clk) begin
        s_start <= start;
        s_cnt   <= byte_count;
    end

    function automatic logic exp_bit(input int t);
        int bp, by, bi;
        bp = t / B;
        by = bp / 10;
        bi = bp % 10;
        if (bi == 0) return 1'b0;
        if (bi == 9) return 1'b1;
        return mem[by][bi-1];
    endfunction

    always @(negedge clk) begin
        logic e_done, e_err, e_tx;
        logic [CW-1:0] e_addr;
        if (rst) begin
            m_busy = 0;
            flip   = 1'b0;
        end else begin
            e_done = 1'b0;
            e_err  = 1'b0;
            if (m_busy == 0) begin
                if (s_start) begin
                    if (s_cnt == 0) e_done = 1'b1;
                    else begin m_busy = 1; m_t = 0; m_n = int'(s_cnt); end
                end
            end else if ((m_t % B) == MID && flip) begin
                e_err = 1'b1; m_busy = 0;
            end else if (m_t == m_n * 10 * B - 1) begin
                e_done = 1'b1; m_busy = 0;
            end else begin
                m_t++;
            end
            e_tx   = m_busy ? exp_bit(m_t) : 1'b1;
            e_addr = m_busy ? CW'(m_t / (10 * B) + 1) : '0;
            checks++;
            if (tx_line !== e_tx || done !== e_done || bit_error !== e_err || rd_addr !== e_addr) begin
                errors++;
                $display("FAIL %s t=%0t tx/done/err/addr actual %b %b %b %0d expected %b %b %b %0d",
                         cur_req, $time, tx_line, done, bit_error, rd_addr, e_tx, e_done, e_err, e_addr);
            end
            if (m_busy != 0 && inj_mode == 1)
                flip = ((m_t / B) == inj_bit);
            else if (m_busy != 0 && inj_mode == 2)
                flip = ((m_t / B) == inj_bit) && ((m_t % B) != MID);
            else
                flip = 1'b0;
        end
    end

    task automatic run_resp(input int cnt, input int mode, input int bitpos);
        inj_mode = mode;
        inj_bit  = bitpos;
        @(posedge clk); #1;
        start = 1'b1; byte_count = CW'(cnt);
        @(posedge clk); #1;
        start = 1'b0;
        repeat (2) @(posedge clk);
        while (m_busy != 0) @(posedge clk);
        repeat (3) @(posedge clk);
        #1;
        inj_mode = 0;
    endtask

    initial begin
        for (int i = 0; i < 16; i++) mem[i] = 8'(i * 37 + 5);
        mem[0] = 8'hA5;
        mem[1] = 8'h3C;
        mem[2] = 8'h81;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        checks++;
        if (tx_line !== 1'b1 || done !== 1'b0 || bit_error !== 1'b0 || rd_addr !== '0) begin
            errors++;
            $display("FAIL R1 reset actual %b %b %b %0d expected 1 0 0 0", tx_line, done, bit_error, rd_addr);
        end
        @(posedge clk); #1;
        rst = 1'b0;
        repeat (4) @(posedge clk);

        cur_req = "R2 R3 R7 single byte";
        run_resp(1, 0, -1);
        cur_req = "R4 three bytes";
        run_resp(3, 0, -1);
        cur_req = "R8 zero count";
        run_resp(0, 0, -1);
        cur_req = "R5 error on start bit";
        run_resp(2, 1, 0);
        cur_req = "R5 error on data bit of second byte";
        run_resp(3, 1, 13);
        cur_req = "R5 error on final stop bit";
        run_resp(2, 1, 19);
        cur_req = "R6 off-middle disturbance";
        run_resp(2, 2, 5);
        cur_req = "R6 off-middle disturbance on stop";
        run_resp(1, 2, 9);

        cur_req = "R9 start while busy";
        @(posedge clk); #1;
        start = 1'b1; byte_count = CW'(2);
        @(posedge clk); #1;
        start = 1'b0;
        repeat (30) @(posedge clk); #1;
        start = 1'b1; byte_count = CW'(5);
        @(posedge clk); #1;
        start = 1'b0;
        repeat (2) @(posedge clk);
        while (m_busy != 0) @(posedge clk);
        repeat (3) @(posedge clk); #1;

        cur_req = "R10 idle readback ignored";
        rx_force = 1'b1;
        repeat (40) @(posedge clk); #1;
        rx_force = 1'b0;
        cur_req = "R4 long response";
        run_resp(6, 0, -1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        finished = 1;
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired actual running expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule